// File: doc/BRIEF.md
# Privileged Register File with Masked Writes

This block holds the privileged control registers of a processor core. A single read port and a single write port address the registers by a 6-bit index. Every index has its own write behaviour. Some keep the whole word. Some keep only selected bits. Some clear themselves on any write. Some are read-only, some are write-only, and the rest of the index space is unmapped. An access that the index does not allow raises an error flag and changes no state.

One register reads back as a cycle count. Its upper half is stored, and its lower half is the live value of a free-running counter. Four write-only indices do not hold data. Instead they send one-cycle command strobes to an external translation buffer: flush everything, or flush a single address tagged with the current address-space number. While the speculative-suppress input is high, every write is dropped. That includes its error flag and its command strobe.

Reads are combinational. Writes take effect on the rising clock edge, so a read of the same index in the same cycle returns the old value.

Top module: `priv_regfile`

## Requirements
- R1: After a synchronous reset, every readable index reads zero, with three exceptions: index 8 reads the VEC_BASE_RST parameter, index 9 reads 0x6, and index 4 reads the cpu_id input zero-extended.
- R2: Indices 0 to 9 and 22 store the full 64-bit write data. rd_data depends only on the current rd_idx. A read of an index in the same cycle as a write to it returns the value held before the write.
- R3: Writes are masked per index. Index 10 stores data with bit 1 forced to 0. Indices 11 and 12 keep bits 3:0. Index 13 keeps bits 4:0. Index 14 keeps bits 4:3. Index 16 keeps bits 18:4. Index 17 keeps bits 5:0. Index 18 keeps bits 10:4. Index 19 keeps bits 63:57.
- R4: Any write to index 20 or index 21 sets that register to zero, whatever the data.
- R5: A read of index 22 returns the stored bits 63:32 joined with bits 31:0 of a free-running counter. The counter is 0 during reset and increases by one on every rising edge once reset is released.
- R6: The following accesses are rejected. A write to a read-only index (23 or 24, which always read 0) raises wr_err. A read of a write-only index (15, 25, 26, 27, 28) raises rd_err. Any access to an unmapped index (29 to 63) raises the matching flag. Both flags are combinational. A rejected read returns 0, and a rejected write changes no register and sends no command.
- R7: A write to index 25 (data side) or index 27 (instruction side) raises tb_flush_all for exactly the next cycle. During that pulse, tb_instr_side is 0 for the data side and 1 for the instruction side, and tb_addr and tb_asn are 0.
- R8: A write to index 26 (data side) or index 28 (instruction side) raises tb_flush_one for exactly the next cycle. During that pulse, tb_addr equals the write data. tb_asn equals bits 63:57 of index 19 for the data side, or bits 10:4 of index 18 for the instruction side, both taken as they were when the write occurred. Outside any pulse, tb_instr_side, tb_addr and tb_asn are 0.
- R9: While spec_hold is high, a write changes no register, raises no wr_err and sends no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_id | input | CPU_ID_W | Identifier loaded into index 4 during reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | 6 | Read index |
| rd_data | output | 64 | Read data, 0 when idle or rejected |
| rd_err | output | 1 | Read of a non-readable index |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data |
| spec_hold | input | 1 | Discards writes while high |
| wr_err | output | 1 | Write to a non-writable index |
| tb_flush_all | output | 1 | Flush-everything command pulse |
| tb_flush_one | output | 1 | Flush-single-address command pulse |
| tb_instr_side | output | 1 | Command targets the instruction side |
| tb_addr | output | 64 | Address carried by a single flush |
| tb_asn | output | 7 | Address-space number carried by a single flush |

## Verification
The hardest case to reach from the ports is a single-address flush whose tb_asn must reflect an address-space number written earlier. The number is packed into an unusual bit field and can only be read back through a masked register. The stimulus first writes all-ones and then patterned data to indices 18 and 19. It then issues flushes on both sides, and writes the address-space registers immediately before a flush so that the old-versus-new timing is exercised. Suppressed writes are placed both on storing indices and on flush indices, and the cycle after each one is compared. A long run of pseudo-random accesses across the mapped indices and an unmapped index completes the coverage. A behavioural model compares every output on every clock.

// File: rtl/priv_regfile_pkg.sv
// Package: index map, write-attribute types and decode helpers for the
// privileged register file. Assumes a 64-bit register word and a 6-bit index.
package priv_regfile_pkg;

    localparam int REG_W  = 64;
    localparam int IDX_W  = 6;
    localparam int ASN_W  = 7;

    // index map
    localparam int NUM_SCRATCH = 8;
    localparam int IX_CPU_SCR  = 4;
    localparam int IX_VBASE    = 8;
    localparam int IX_CTLST    = 9;
    localparam int IX_FPC      = 10;
    localparam int IX_TRQ      = 11;
    localparam int IX_TEN      = 12;
    localparam int IX_PRIO     = 13;
    localparam int IX_CMODE    = 14;
    localparam int IX_AMODE    = 15;
    localparam int IX_SWI      = 16;
    localparam int IX_CACHE    = 17;
    localparam int IX_IASN     = 18;
    localparam int IX_DASN     = 19;
    localparam int IX_XSUM     = 20;
    localparam int IX_XMSK     = 21;
    localparam int IX_CYC      = 22;
    localparam int IX_INTID    = 23;
    localparam int IX_MMST     = 24;
    localparam int IX_DFALL    = 25;
    localparam int IX_DFONE    = 26;
    localparam int IX_IFALL    = 27;
    localparam int IX_IFONE    = 28;
    localparam int N_STORE     = IX_CYC + 1;

    // address-space-number field positions
    localparam int IASN_LSB = 4;
    localparam int DASN_LSB = REG_W - ASN_W;

    localparam logic [REG_W-1:0] CTLST_RST = 64'h6;

    typedef enum logic [2:0] {
        K_NONE, K_STORE, K_ZERO, K_DROP, K_FLUSH_ALL, K_FLUSH_ONE
    } wkind_e;

    typedef struct packed {
        logic             wr_ok;
        wkind_e           kind;
        logic             instr_side;
        logic [REG_W-1:0] mask;
    } wattr_t;

    // True when the index may be read.
    function automatic logic idx_readable(input logic [IDX_W-1:0] idx);
        int i;
        i = int'(idx);
        return (i <= IX_MMST) && (i != IX_AMODE);
    endfunction

    // Write attributes for an index.
    function automatic wattr_t idx_write_attr(input logic [IDX_W-1:0] idx);
        wattr_t a;
        a = '{wr_ok: 1'b1, kind: K_STORE, instr_side: 1'b0, mask: '1};
        if (int'(idx) >= NUM_SCRATCH) begin
            case (int'(idx))
                IX_VBASE, IX_CTLST, IX_CYC: a.mask = '1;
                IX_FPC:   a.mask = ~64'h2;
                IX_TRQ, IX_TEN: a.mask = 64'hf;
                IX_PRIO:  a.mask = 64'h1f;
                IX_CMODE: a.mask = 64'h18;
                IX_SWI:   a.mask = 64'h7fff0;
                IX_CACHE: a.mask = 64'h3f;
                IX_IASN:  a.mask = 64'h7f0;
                IX_DASN:  a.mask = 64'hfe00_0000_0000_0000;
                IX_XSUM, IX_XMSK: a.kind = K_ZERO;
                IX_AMODE: a.kind = K_DROP;
                IX_DFALL: a.kind = K_FLUSH_ALL;
                IX_DFONE: a.kind = K_FLUSH_ONE;
                IX_IFALL: begin a.kind = K_FLUSH_ALL; a.instr_side = 1'b1; end
                IX_IFONE: begin a.kind = K_FLUSH_ONE; a.instr_side = 1'b1; end
                default:  begin a.wr_ok = 1'b0; a.kind = K_NONE; a.mask = '0; end
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/prf_wr_decode.sv
// Module: prf_wr_decode
// Turns a write index into its legality, write kind, side and bit mask.
// Purely combinational; assumes the index map of priv_regfile_pkg.
module prf_wr_decode
    import priv_regfile_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic             wr_ok,
    output wkind_e           kind,
    output logic             instr_side,
    output logic [REG_W-1:0] mask
);
    wattr_t attr;

    // look up the attributes of the addressed index
    always_comb attr = idx_write_attr(idx);

    assign wr_ok      = attr.wr_ok;
    assign kind       = attr.kind;
    assign instr_side = attr.instr_side;
    assign mask       = attr.mask;
endmodule

// File: rtl/prf_cycle_counter.sv
// Module: prf_cycle_counter
// Free-running cycle counter, held at zero in reset and wrapping at its width.
module prf_cycle_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    // advance by one every cycle outside reset
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // R5: count advances by exactly one per cycle after reset
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/prf_tb_cmd.sv
// Module: prf_tb_cmd
// Registers the translation-buffer command for one cycle after the write.
// Assumes at most one of fire_all / fire_one is high. Payload is zero when idle.
module prf_tb_cmd #(
    parameter int ADDR_W = 64,
    parameter int ASN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_all,
    input  logic              fire_one,
    input  logic              instr_side,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ASN_W-1:0]  asn,
    output logic              flush_all,
    output logic              flush_one,
    output logic              instr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ASN_W-1:0]  asn_o
);
    // capture the command and its payload as a single-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_all <= 1'b0;
            flush_one <= 1'b0;
            instr_o   <= 1'b0;
            addr_o    <= '0;
            asn_o     <= '0;
        end else begin
            flush_all <= fire_all;
            flush_one <= fire_one;
            instr_o   <= (fire_all || fire_one) && instr_side;
            addr_o    <= fire_one ? addr : '0;
            asn_o     <= fire_one ? asn  : '0;
        end
    end

    // R7/R8: never both commands in one cycle
    a_r7_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_all, flush_one}));

    // R8: payload is zero outside a single-address flush
    a_r8_idle_payload: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_one |-> (addr_o == '0 && asn_o == '0));
endmodule

// File: rtl/priv_regfile.sv
// Module: priv_regfile
// Privileged control register file with per-index write masks, write-to-clear
// registers, read/write legality checks, a merged cycle count and
// translation-buffer command strobes. Reads are combinational; writes land on
// the rising edge. Assumes a synchronous active-low reset and CYC_W < 64.
module priv_regfile
    import priv_regfile_pkg::*;
#(
    parameter int               CPU_ID_W     = 8,
    parameter int               CYC_W        = 32,
    parameter logic [REG_W-1:0] VEC_BASE_RST = 64'h0000_0000_0002_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CPU_ID_W-1:0] cpu_id,
    input  logic                rd_en,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [REG_W-1:0]    rd_data,
    output logic                rd_err,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                spec_hold,
    output logic                wr_err,
    output logic                tb_flush_all,
    output logic                tb_flush_one,
    output logic                tb_instr_side,
    output logic [REG_W-1:0]    tb_addr,
    output logic [ASN_W-1:0]    tb_asn
);
    localparam int SEL_W = $clog2(N_STORE);

    logic [N_STORE-1:0][REG_W-1:0] regs;
    logic [CYC_W-1:0]              cyc_now;
    logic                          w_ok, w_instr, w_fire, rd_ok;
    wkind_e                        w_kind;
    logic [REG_W-1:0]              w_mask;
    logic [ASN_W-1:0]              cur_asn;

    prf_wr_decode u_wdec (
        .idx        (wr_idx),
        .wr_ok      (w_ok),
        .kind       (w_kind),
        .instr_side (w_instr),
        .mask       (w_mask)
    );

    prf_cycle_counter #(.CNT_W(CYC_W)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cyc_now)
    );

    // a write is committed only when legal and not suppressed
    assign w_fire = wr_en && !spec_hold && w_ok;
    assign wr_err = wr_en && !spec_hold && !w_ok;

    // storage, one register per stored index with its own reset value
    for (genvar g = 0; g < N_STORE; g++) begin : g_reg
        logic [REG_W-1:0] init_v;
        if (g == IX_CPU_SCR) begin : g_cpu
            assign init_v = REG_W'(cpu_id);
        end else if (g == IX_VBASE) begin : g_vbase
            assign init_v = VEC_BASE_RST;
        end else if (g == IX_CTLST) begin : g_ctl
            assign init_v = CTLST_RST;
        end else begin : g_zero
            assign init_v = '0;
        end

        // load reset value, then apply masked or clearing writes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= init_v;
            end else if (w_fire && wr_idx == IDX_W'(g)) begin
                case (w_kind)
                    K_STORE: regs[g] <= wr_data & w_mask;
                    K_ZERO:  regs[g] <= '0;
                    default: ;
                endcase
            end
        end
    end

    // read mux with cycle-count merge on the counter index
    always_comb begin
        rd_ok   = idx_readable(rd_idx);
        rd_err  = rd_en && !rd_ok;
        rd_data = '0;
        if (rd_en && rd_ok) begin
            if (rd_idx == IDX_W'(IX_CYC))
                rd_data = {regs[IX_CYC][REG_W-1:CYC_W], cyc_now};
            else if (int'(rd_idx) < N_STORE)
                rd_data = regs[rd_idx[SEL_W-1:0]];
        end
    end

    // address-space number for the side being flushed
    assign cur_asn = w_instr ? regs[IX_IASN][IASN_LSB +: ASN_W]
                             : regs[IX_DASN][DASN_LSB +: ASN_W];

    prf_tb_cmd #(.ADDR_W(REG_W), .ASN_W(ASN_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_all   (w_fire && w_kind == K_FLUSH_ALL),
        .fire_one   (w_fire && w_kind == K_FLUSH_ONE),
        .instr_side (w_instr),
        .addr       (wr_data),
        .asn        (cur_asn),
        .flush_all  (tb_flush_all),
        .flush_one  (tb_flush_one),
        .instr_o    (tb_instr_side),
        .addr_o     (tb_addr),
        .asn_o      (tb_asn)
    );

    // R3: priority level never holds bits above bit 4
    a_r3_prio_bits: assert property (@(posedge clk) disable iff (!rst_n)
        regs[IX_PRIO][REG_W-1:5] == '0);

    // R4: exception summary reads zero after any unsuppressed write
    a_r4_sum_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !spec_hold && wr_idx == IDX_W'(IX_XSUM)) |=> regs[IX_XSUM] == '0);

    // R5: low half of the counter register read is the live count
    a_r5_cyc_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == IDX_W'(IX_CYC)) |-> rd_data[CYC_W-1:0] == cyc_now);

    // R6: a rejected write leaves every register unchanged
    a_r6_reject_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> $stable(regs));

    // R6: a rejected read returns zero
    a_r6_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_data == '0);

    // R9: suppressed writes change no register and issue no command
    a_r9_hold_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && spec_hold) |=> ($stable(regs) && !tb_flush_all && !tb_flush_one));
endmodule

// File: tb/priv_regfile_tb.sv
`timescale 1ns/1ps
module priv_regfile_tb;
    localparam logic [63:0] VBASE = 64'h0000_0000_0002_0000;
    localparam logic [7:0]  CPUID = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_id = CPUID;
    logic        rd_en = 1'b0, wr_en = 1'b0, spec_hold = 1'b0;
    logic [5:0]  rd_idx = '0, wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data, tb_addr;
    logic        rd_err, wr_err, tb_flush_all, tb_flush_one, tb_instr_side;
    logic [6:0]  tb_asn;

    always #2 clk = ~clk;

    priv_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .spec_hold(spec_hold),
        .wr_err(wr_err), .tb_flush_all(tb_flush_all), .tb_flush_one(tb_flush_one),
        .tb_instr_side(tb_instr_side), .tb_addr(tb_addr), .tb_asn(tb_asn)
    );

    // behavioural reference state
    logic [63:0] m [0:63];
    logic [31:0] mcyc = '0;
    logic        e_fa = 0, e_fo = 0, e_side = 0;
    logic [63:0] e_addr = '0;
    logic [6:0]  e_asn = '0;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference cycle counter
    always @(posedge clk) mcyc <= rst_n ? mcyc + 1 : 32'd0;

    function automatic bit m_rd_ok(int i);
        return i <= 24 && i != 15;
    endfunction
    function automatic bit m_wr_ok(int i);
        return i <= 22 || (i >= 25 && i <= 28);
    endfunction
    function automatic string tag_of(int i);
        if (i <= 9) return "R2";
        if (i == 20 || i == 21) return "R4";
        if (i == 22) return "R5";
        if (i <= 19 && i != 15) return "R3";
        return "R6";
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock of stimulus, compare, then advance the model
    task automatic step(bit re, int ri, bit we, int wi, logic [63:0] wd, bit sp, string tg);
        logic [63:0] er;
        bit ok;
        @(negedge clk);
        rd_en = re; rd_idx = 6'(ri); wr_en = we; wr_idx = 6'(wi);
        wr_data = wd; spec_hold = sp;
        #1;
        ok = m_rd_ok(ri);
        er = 64'h0;
        if (re && ok) er = (ri == 22) ? {m[22][63:32], mcyc} : m[ri];
        chk(tg != "" ? tg : tag_of(ri), $sformatf("rd_err idx %0d", ri), 64'(rd_err), 64'(re && !ok));
        chk(tg != "" ? tg : tag_of(ri), $sformatf("rd_data idx %0d", ri), rd_data, er);
        chk(tg != "" ? tg : (sp ? "R9" : "R6"), $sformatf("wr_err idx %0d", wi), 64'(wr_err),
            64'(we && !sp && !m_wr_ok(wi)));
        chk(tg != "" ? tg : (e_fo ? "R8" : "R7"), "cmd flags",
            {61'd0, tb_flush_all, tb_flush_one, tb_instr_side}, {61'd0, e_fa, e_fo, e_side});
        chk(tg != "" ? tg : "R8", "cmd addr", tb_addr, e_addr);
        chk(tg != "" ? tg : "R8", "cmd asn", 64'(tb_asn), 64'(e_asn));
        @(posedge clk);
        e_fa = 0; e_fo = 0; e_side = 0; e_addr = '0; e_asn = '0;
        if (we && !sp) begin
            case (wi)
                0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 22: m[wi] = wd;
                10: m[wi] = wd & ~64'h2;
                11, 12: m[wi] = wd & 64'hf;
                13: m[wi] = wd & 64'h1f;
                14: m[wi] = wd & 64'h18;
                16: m[wi] = wd & 64'h7fff0;
                17: m[wi] = wd & 64'h3f;
                18: m[wi] = wd & 64'h7f0;
                19: m[wi] = wd & 64'hfe00_0000_0000_0000;
                20, 21: m[wi] = '0;
                25, 27: begin e_fa = 1; e_side = (wi == 27); end
                26, 28: begin
                    e_fo = 1; e_side = (wi == 28); e_addr = wd;
                    e_asn = (wi == 26) ? m[19][63:57] : m[18][10:4];
                end
                default: ;
            endcase
        end
    endtask

    task automatic idle(string tg);
        step(0, 0, 0, 0, '0, 0, tg);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m[i] = '0;
        m[4] = 64'(CPUID); m[8] = VBASE; m[9] = 64'h6;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        step(1, 4, 0, 0, '0, 0, "R1");
        step(1, 8, 0, 0, '0, 0, "R1");
        step(1, 9, 0, 0, '0, 0, "R1");
        step(1, 0, 0, 0, '0, 0, "R1");
        step(1, 13, 0, 0, '0, 0, "R1");
        step(1, 22, 0, 0, '0, 0, "R1");

        // R2: full stores, same-cycle read returns old value
        step(1, 3, 1, 3, 64'hDEAD_BEEF_0123_4567, 0, "R2");
        step(1, 3, 1, 8, 64'hFFFF_0000_FFFF_0000, 0, "R2");
        step(1, 8, 0, 0, '0, 0, "R2");

        // R3: masks, all-ones written then read back
        for (int i = 10; i <= 19; i++) step(0, 0, i != 15, i, '1, 0, "R3");
        for (int i = 10; i <= 19; i++) if (i != 15) step(1, i, 0, 0, '0, 0, "R3");

        // R4: write-to-clear
        step(0, 0, 1, 20, '1, 0, "R4");
        step(1, 20, 1, 21, 64'h1234, 0, "R4");
        step(1, 21, 0, 0, '0, 0, "R4");

        // R5: counter merge
        step(0, 0, 1, 22, 64'hAAAA_AAAA_5555_5555, 0, "R5");
        step(1, 22, 0, 0, '0, 0, "R5");
        step(1, 22, 0, 0, '0, 0, "R5");

        // R6: illegal accesses
        step(1, 23, 1, 23, '1, 0, "R6");
        step(1, 23, 1, 24, '1, 0, "R6");
        step(1, 25, 1, 40, '1, 0, "R6");
        step(1, 40, 0, 0, '0, 0, "R6");
        step(1, 15, 1, 15, '1, 0, "R6");

        // R7: flush-all both sides
        step(0, 0, 1, 25, '1, 0, "R7");
        step(0, 0, 1, 27, '1, 0, "R7");
        idle("R7");
        idle("R7");

        // R8: single flush with address-space numbers
        step(0, 0, 1, 19, 64'hA400_0000_0000_0000, 0, "R8");
        step(0, 0, 1, 26, 64'h0000_1234_5678_9000, 0, "R8");
        step(0, 0, 1, 18, 64'h0000_0000_0000_05A0, 0, "R8");
        step(0, 0, 1, 28, 64'h0000_0000_CAFE_0000, 0, "R8");
        step(0, 0, 1, 19, '1, 0, "R8");
        step(0, 0, 1, 26, 64'h77, 0, "R8");
        idle("R8");

        // R9: suppressed writes
        step(0, 0, 1, 0, '1, 1, "R9");
        step(1, 0, 1, 26, '1, 1, "R9");
        step(1, 0, 1, 23, '1, 1, "R9");
        idle("R9");

        // mixed pseudo-random traffic
        for (int n = 0; n < 3000; n++) begin
            int ri, wi;
            ri = ($urandom_range(0, 15) == 0) ? 63 : int'($urandom_range(0, 31));
            wi = ($urandom_range(0, 15) == 0) ? 50 : int'($urandom_range(0, 31));
            step($urandom_range(0, 1) == 1, ri, $urandom_range(0, 2) != 0, wi,
                 {$urandom, $urandom}, $urandom_range(0, 7) == 0, "");
        end
        idle("");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule